// File: doc/BRIEF.md
# Display Data Channel Two-Space I2C Target

This block is the serial target that sits on the display data channel of a video sink. It recognises two address pairs on a single I2C bus. One pair serves an identification-data store held in a single-port RAM. The other pair serves a small file of status and control registers. The bus side has the usual open-drain behaviour: the block only ever pulls SDA low and never drives SCL, and it never stretches the clock.

A transfer works the same way in both spaces. A write transfer carries the byte offset in its first data byte. Reads then continue from that offset, and the offset moves up by one for each byte transferred. A low-nibble rate field in the register file is also brought out as a port. Whenever that field changes through a bus write, or a hot-plug input rises, the block emits a one-cycle training-start pulse. A local host fills the RAM through a valid/ready write port. Ready is low from a bus START until the matching STOP, so a write that is held waits for an idle bus, and the host must keep valid and its data steady until ready is seen.

Top module: `ddc_scdc_target`

## Requirements
- R1: The block acknowledges 8-bit bus address 0xA0 (write) and 0xA1 (read) and serves the identification RAM there. Address bit 0 set to 1 means read and 0 means write.
- R2: The block acknowledges 0xA8 (write) and 0xA9 (read) and serves the register file there.
- R3: Any other address byte is not acknowledged. SDA stays released, the engine returns to idle (host_wr_ready goes high again), and later bytes of that transfer change nothing.
- R4: In a write transfer, the first data byte loads the offset pointer. Each later byte is acknowledged, is stored in the register file at the pointer, and then advances the pointer. Register offsets at or above REG_COUNT ignore writes and read as 0x00.
- R5: A read transfer returns bytes starting at the current pointer, and the pointer advances by one per byte, wrapping from 0xFF to 0x00. The controller ends the read by not acknowledging a byte.
- R6: Reads from the identification space return the RAM bytes last written through the host port.
- R7: Data bytes written over the bus to the identification space are acknowledged but leave the RAM unchanged; only the pointer moves.
- R8: host_wr_ready is low from START to STOP of an addressed transfer. A host write happens exactly on a clock where host_wr_valid and host_wr_ready are both high.
- R9: link_rate_o equals bits [3:0] of register offset 0x31 and resets to 0.
- R10: A bus write to offset 0x31 whose bits [3:0] differ from the stored value gives one train_start_o pulse. A write with equal bits [3:0] gives no pulse, even if the upper bits differ.
- R11: A rising edge on hpd_i gives one single-cycle train_start_o pulse; a falling edge gives none.
- R12: A repeated START at any point restarts address decoding.
- R13: SCL and SDA are synchronised with two flops and filtered. A level must hold for FILT_LEN consecutive clocks to be seen, so a shorter glitch on SDA while SCL is high is not taken as START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| hpd_i | input | 1 | Hot-plug level (asynchronous) |
| host_wr_valid | input | 1 | Host RAM write request |
| host_wr_ready | output | 1 | Host write accepted when high with valid |
| host_wr_addr | input | EDID_AW | Host RAM byte address |
| host_wr_data | input | 8 | Host RAM byte |
| train_start_o | output | 1 | One-cycle link-training request |
| link_rate_o | output | 4 | Current rate field |

## Verification
The bench goes after the pointer. Reads that continue across transfers, a wrap past 0xFF and register offsets beyond the file are all checked. A design that mixed up the first-byte rule or incremented at the wrong point would return shifted data. It also checks that a rate write with unchanged low bits but new upper bits stays silent, since comparing the whole byte would emit a spurious pulse. A host request is held during an active transfer to catch a RAM port that ignores ready. A two-clock SDA dip while SCL is high is used to catch a filter that is too short, which would show up as a false START dropping host_wr_ready.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_RX, ST_ACK_W, ST_TX, ST_MACK, ST_WAIT
  } bus_st_e;

  localparam logic [6:0] EDID_ID = 7'h50;
  localparam logic [6:0] CTRL_ID = 7'h54;
endpackage

// File: rtl/ddc_line_filter.sv
module ddc_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        dout <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddc_bus_engine.sv
module ddc_bus_engine
  import ddc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  input  logic [7:0] rd_byte,
  output logic       sda_low,
  output logic       busy,
  output logic       sel_ctrl,
  output logic [7:0] ptr,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);
  bus_st_e    st;
  logic       scl_q, sda_q, rnw, first, mack;
  logic [3:0] bitcnt;
  logic [7:0] sh, tx;

  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire is_start = scl & scl_q & sda_q & ~sda;
  wire is_stop  = scl & scl_q & ~sda_q & sda;
  wire id_hit   = (sh[7:1] == EDID_ID) || (sh[7:1] == CTRL_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
      sda_low <= 1'b0; busy <= 1'b0; sel_ctrl <= 1'b0;
      rnw <= 1'b0; first <= 1'b0; mack <= 1'b0;
      bitcnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      scl_q  <= scl;
      sda_q  <= sda;
      wr_stb <= 1'b0;
      if (is_start) begin
        st <= ST_ADDR; bitcnt <= '0; sda_low <= 1'b0; busy <= 1'b1;
      end else if (is_stop) begin
        st <= ST_IDLE; sda_low <= 1'b0; busy <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda}; bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (id_hit) begin
                sda_low  <= 1'b1;
                sel_ctrl <= (sh[7:1] == CTRL_ID);
                rnw      <= sh[0];
                first    <= ~sh[0];
                st       <= ST_ACK_A;
              end else begin
                st <= ST_IDLE; busy <= 1'b0;
              end
            end
          end
          ST_ACK_A: if (scl_fall) begin
            bitcnt <= '0;
            if (rnw) begin
              tx <= rd_byte; sda_low <= ~rd_byte[7]; st <= ST_TX;
            end else begin
              sda_low <= 1'b0; st <= ST_RX;
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda}; bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              sda_low <= 1'b1;
              st      <= ST_ACK_W;
              if (first) begin
                ptr <= sh; first <= 1'b0;
              end else begin
                wr_stb <= 1'b1; wr_addr <= ptr; wr_data <= sh;
                ptr <= ptr + 1'b1;
              end
            end
          end
          ST_ACK_W: if (scl_fall) begin
            sda_low <= 1'b0; bitcnt <= '0; st <= ST_RX;
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_low <= 1'b0; ptr <= ptr + 1'b1; st <= ST_MACK;
            end else begin
              tx <= {tx[6:0], 1'b0}; sda_low <= ~tx[6]; bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_MACK: begin
            if (scl_rise) mack <= ~sda;
            else if (scl_fall) begin
              if (mack) begin
                tx <= rd_byte; sda_low <= ~rd_byte[7]; bitcnt <= '0; st <= ST_TX;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: the target never moves SDA while SCL is held high
  p_sda_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl)) |-> $stable(sda_low));
  // R4: stores only come out of the receive phase
  p_wr_after_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(st == ST_RX));
  // R3: leaving a transfer always leaves SDA released
  p_release_on_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !sda_low);
endmodule

// File: rtl/ddc_edid_ram.sv
module ddc_edid_ram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else    rdata     <= mem[addr];
  end
endmodule

// File: rtl/ddc_ctrl_regs.sv
module ddc_ctrl_regs #(
  parameter int         REG_AW    = 6,
  parameter logic [7:0] RATE_ADDR = 8'h31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  input  logic       hpd,
  output logic [7:0] rd_data,
  output logic [3:0] link_rate,
  output logic       train_start
);
  localparam int REG_COUNT = 1 << REG_AW;
  localparam logic [REG_AW-1:0] RATE_IDX = RATE_ADDR[REG_AW-1:0];

  logic [7:0] regs [REG_COUNT];
  logic       hpd_s1, hpd_s2, hpd_s3;

  wire wr_hit  = wr_en && ({1'b0, wr_addr} < 9'(REG_COUNT));
  wire rd_hit  = {1'b0, rd_addr} < 9'(REG_COUNT);
  wire rate_wr = wr_en && (wr_addr == RATE_ADDR) &&
                 (wr_data[3:0] != regs[RATE_IDX][3:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
      hpd_s1 <= 1'b0; hpd_s2 <= 1'b0; hpd_s3 <= 1'b0;
      train_start <= 1'b0;
    end else begin
      hpd_s1 <= hpd; hpd_s2 <= hpd_s1; hpd_s3 <= hpd_s2;
      if (wr_hit) regs[wr_addr[REG_AW-1:0]] <= wr_data;
      train_start <= rate_wr | (hpd_s2 & ~hpd_s3);
    end
  end

  assign rd_data   = rd_hit ? regs[rd_addr[REG_AW-1:0]] : 8'h00;
  assign link_rate = regs[RATE_IDX][3:0];

  // R10: every change of the rate field comes with a training request
  p_rate_change_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (link_rate != $past(link_rate)) |-> train_start);
endmodule

// File: rtl/ddc_scdc_target.sv
module ddc_scdc_target #(
  parameter int FILT_LEN = 3,
  parameter int REG_AW   = 6,
  parameter int EDID_AW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic               hpd_i,
  input  logic               host_wr_valid,
  output logic               host_wr_ready,
  input  logic [EDID_AW-1:0] host_wr_addr,
  input  logic [7:0]         host_wr_data,
  output logic               train_start_o,
  output logic [3:0]         link_rate_o
);
  logic scl_f, sda_f, busy, sel_ctrl, wr_stb;
  logic [7:0] ptr, wr_addr, wr_data, ram_rd, reg_rd, rd_byte;
  logic [EDID_AW-1:0] ram_addr;
  logic ram_we;

  ddc_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
  ddc_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

  ddc_bus_engine u_engine (
    .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f), .rd_byte(rd_byte),
    .sda_low(sda_oe), .busy(busy), .sel_ctrl(sel_ctrl), .ptr(ptr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  assign host_wr_ready = ~busy;
  assign ram_we        = host_wr_valid & ~busy;
  assign ram_addr      = busy ? ptr[EDID_AW-1:0] : host_wr_addr;

  ddc_edid_ram #(.AW(EDID_AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(host_wr_data), .rdata(ram_rd));

  ddc_ctrl_regs #(.REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_stb & sel_ctrl), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .hpd(hpd_i), .rd_data(reg_rd),
    .link_rate(link_rate_o), .train_start(train_start_o));

  assign rd_byte = sel_ctrl ? reg_rd : ram_rd;

  // R9: with the bus idle the rate field cannot move
  p_rate_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(link_rate_o));
endmodule

// File: tb/ddc_scdc_target_tb_top.sv
module ddc_scdc_target_tb_top;
  localparam int Q = 10;
  localparam logic [6:0] ID_E = 7'h50, ID_C = 7'h54;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, m_scl, m_sda, hpd, h_valid;
  logic [7:0] h_addr, h_data;
  logic sda_oe, h_ready, train;
  logic [3:0] rate;
  wire bus_sda = m_sda & ~sda_oe;

  ddc_scdc_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(sda_oe),
    .hpd_i(hpd), .host_wr_valid(h_valid), .host_wr_ready(h_ready),
    .host_wr_addr(h_addr), .host_wr_data(h_data),
    .train_start_o(train), .link_rate_o(rate));

  int checks = 0, errors = 0, mdl_ptr = 0, mdl_pulses = 0, seen_pulses = 0;
  logic [7:0] mdl_edid [256];
  logic [7:0] mdl_regs [64];
  logic [3:0] mdl_rate = 4'h0;
  bit in_txn = 1'b1, done = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model while the bus is quiet
  always @(negedge clk) if (rst_n && !in_txn && !done) begin
    chk(rate == mdl_rate, "R9", rate, mdl_rate);
    chk(h_ready == 1'b1, "R13", h_ready, 1);
    chk(sda_oe == 1'b0, "R3", sda_oe, 0);
  end
  always @(posedge clk) if (rst_n && train) seen_pulses++;

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start();
    m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq();
  endtask
  task automatic i2c_stop();
    m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq();
  endtask
  task automatic send_bit(bit b);
    m_sda = b; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq();
  endtask
  task automatic recv_bit(output bit b);
    m_sda = 1; wq(); m_scl = 1; wq(); b = bus_sda; wq(); m_scl = 0; wq();
  endtask
  task automatic send_byte(logic [7:0] d, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a); ack = ~a;
  endtask
  task automatic recv_byte(output logic [7:0] d, input bit mack);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(~mack);
  endtask
  task automatic end_txn();
    wq(); wq(); in_txn = 1'b0;
  endtask

  function automatic logic [7:0] reg_rd(int p);
    return (p < 64) ? mdl_regs[p] : 8'h00;
  endfunction

  task automatic write_txn(logic [6:0] dev, logic [7:0] off, logic [7:0] data[$], string req);
    bit ack;
    in_txn = 1'b1; i2c_start();
    send_byte({dev, 1'b0}, ack); chk(ack, req, ack, 1);
    send_byte(off, ack); chk(ack, req, ack, 1);
    mdl_ptr = off;
    foreach (data[k]) begin
      send_byte(data[k], ack); chk(ack, req, ack, 1);
      if (dev == ID_C && mdl_ptr < 64) begin
        if (mdl_ptr == 8'h31 && data[k][3:0] != mdl_rate) begin
          mdl_pulses++; mdl_rate = data[k][3:0];
        end
        mdl_regs[mdl_ptr] = data[k];
      end
      mdl_ptr = (mdl_ptr + 1) % 256;
    end
    i2c_stop(); end_txn();
  endtask

  task automatic read_txn(logic [6:0] dev, bit set, logic [7:0] off, int n, string req);
    bit ack; logic [7:0] d, e;
    in_txn = 1'b1; i2c_start();
    if (set) begin
      send_byte({dev, 1'b0}, ack); chk(ack, req, ack, 1);
      send_byte(off, ack); chk(ack, req, ack, 1);
      mdl_ptr = off;
      i2c_start();
    end
    send_byte({dev, 1'b1}, ack); chk(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      e = (dev == ID_E) ? mdl_edid[mdl_ptr] : reg_rd(mdl_ptr);
      chk(d === e, req, d, e);
      mdl_ptr = (mdl_ptr + 1) % 256;
    end
    i2c_stop(); end_txn();
  endtask

  task automatic host_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); h_valid = 1; h_addr = a; h_data = d;
    while (!h_ready) @(negedge clk);
    @(negedge clk); h_valid = 0;
    mdl_edid[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    rst_n = 0; m_scl = 1; m_sda = 1; hpd = 0; h_valid = 0; h_addr = 0; h_data = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk(sda_oe == 0, "R3", sda_oe, 0);
    chk(h_ready == 1, "R8", h_ready, 1);
    chk(train == 0 && rate == 0, "R9", rate, 0);
    in_txn = 1'b0;

    // R6: host fills the RAM
    for (int k = 0; k < 8; k++) host_write(8'(k), 8'(8'h13 + k * 8'h11));
    host_write(8'hFF, 8'h5A);
    host_write(8'h20, 8'h42);

    // R1 / R6 / R5: pointer set, continued read, wrap
    read_txn(ID_E, 1, 8'h00, 4, "R6");
    read_txn(ID_E, 0, 8'h00, 3, "R5");
    read_txn(ID_E, 1, 8'hFF, 2, "R5");

    // R7: bus writes to the identification space are not stored
    write_txn(ID_E, 8'h05, '{8'h99}, "R7");
    read_txn(ID_E, 1, 8'h05, 1, "R7");

    // R2 / R4: register file burst
    write_txn(ID_C, 8'h10, '{8'h11, 8'h22, 8'h33}, "R4");
    read_txn(ID_C, 1, 8'h10, 3, "R2");
    write_txn(ID_C, 8'h40, '{8'h77}, "R4");
    read_txn(ID_C, 1, 8'h3F, 2, "R4");
    chk(seen_pulses == mdl_pulses, "R10", seen_pulses, mdl_pulses);

    // R10: rate changes and same-rate writes
    write_txn(ID_C, 8'h31, '{8'h05}, "R10");
    chk(seen_pulses == mdl_pulses, "R10", seen_pulses, mdl_pulses);
    write_txn(ID_C, 8'h31, '{8'h25}, "R10");
    chk(seen_pulses == mdl_pulses, "R10", seen_pulses, mdl_pulses);
    read_txn(ID_C, 1, 8'h31, 1, "R9");
    write_txn(ID_C, 8'h30, '{8'hAA, 8'h03, 8'hBB}, "R10");
    chk(seen_pulses == mdl_pulses, "R10", seen_pulses, mdl_pulses);
    chk(rate == 4'h3, "R9", rate, 3);

    // R3: foreign addresses
    in_txn = 1'b1; i2c_start();
    send_byte({7'h58, 1'b0}, ack); chk(!ack, "R3", ack, 0);
    wq(); chk(h_ready == 1, "R3", h_ready, 1);
    send_byte(8'h31, ack); chk(!ack, "R3", ack, 0);
    send_byte(8'h0F, ack); chk(!ack, "R3", ack, 0);
    i2c_stop(); end_txn();
    in_txn = 1'b1; i2c_start();
    send_byte({7'h51, 1'b1}, ack); chk(!ack, "R3", ack, 0);
    i2c_stop(); end_txn();
    chk(rate == 4'h3, "R3", rate, 3);

    // R8: host request held during a transfer must wait
    in_txn = 1'b1; i2c_start();
    send_byte({ID_C, 1'b0}, ack); chk(ack, "R8", ack, 1);
    chk(h_ready == 0, "R8", h_ready, 0);
    @(negedge clk); h_valid = 1; h_addr = 8'h20; h_data = 8'hEE;
    send_byte(8'h00, ack); chk(ack, "R8", ack, 1);
    h_valid = 0;
    i2c_stop(); end_txn();
    read_txn(ID_E, 1, 8'h20, 1, "R8");

    // R11: hot-plug edges
    hpd = 1; repeat (20) @(negedge clk);
    mdl_pulses++;
    chk(seen_pulses == mdl_pulses, "R11", seen_pulses, mdl_pulses);
    hpd = 0; repeat (20) @(negedge clk);
    chk(seen_pulses == mdl_pulses, "R11", seen_pulses, mdl_pulses);

    // R13: short SDA dip with SCL high is filtered out
    @(negedge clk); m_sda = 0;
    repeat (2) @(negedge clk); m_sda = 1;
    repeat (20) @(negedge clk);
    chk(h_ready == 1, "R13", h_ready, 1);
    read_txn(ID_C, 1, 8'h10, 1, "R13");

    // R12: abandoned header followed by repeated START
    in_txn = 1'b1; i2c_start();
    send_byte({ID_C, 1'b0}, ack); chk(ack, "R12", ack, 1);
    read_txn(ID_E, 1, 8'h02, 1, "R12");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule